// File: doc/BRIEF.md
# H-Bridge Switch Control with Per-Leg Fault Latch

This block is the digital control core of a full-bridge motor driver. It takes two direction inputs (one per leg), a PWM input, a test-mode input and the readback of two shared enable/diagnostic lines. From these it produces on/off commands for four power switches: a high-side and a low-side switch in each of leg A and leg B. Gate drive, current limiting and all analog sensing sit outside the block. Their results reach it as digital flags: high-side overtemperature, low-side saturation and load disconnect in test mode.

Every asynchronous input passes through a synchronizer chain of configurable depth. A fault on a leg latches that leg off and asserts the open-drain pull-down for that leg's enable/diagnostic line. The latch holds until that leg's direction input rises again. Each leg runs a small state machine with three states: off, high-side on, and low-side on. A change between the two on-states always passes through a configurable number of cycles with both switches off.

Top module: `hbridge_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears all fault latches, releases both pull-downs and turns all four switches off. Everything in this list treats bit 0 of every two-bit port as leg A and bit 1 as leg B.
- R2: In normal mode, an enabled and unfaulted leg whose direction bit is 1 turns on its high-side switch. If its direction bit is 0 and PWM is 1, it turns on its low-side switch instead. The four direction codes therefore give brake-high, A-high/B-low, A-low/B-high and brake-low.
- R3: While PWM is 0, both low-side switches are off. High-side switches do not depend on PWM.
- R4: While a leg's enable line reads 0, both switches of that leg are off, in every mode. The other leg is not affected.
- R5: The two switches of one leg are never on together. Any change of a leg from one on-state to another spends at least DEAD_CYC consecutive cycles with both of its switches off.
- R6: A high-side overtemperature flag in normal mode latches a fault on that leg. A latched fault turns both switches of that leg off and drives `diag_pd_o` for that leg to 1, which means the line is pulled low.
- R7: A low-side saturation flag raises a fault only while that leg's low-side switch is on. At any other time the flag is ignored.
- R8: A latched fault stays set, whatever the fault flags do, until the synchronized direction bit of that leg goes from 0 to 1. The leg may then turn on again.
- R9: `fault_o` shows the latched fault state of each leg. It stays 1 after the raw flag that caused the fault has dropped.
- R10: In test mode, the low-side switches are never on, and a direction bit of 1 turns on only that leg's high-side switch. A load-disconnect flag on a leg in test mode latches a fault on that leg.
- R11: Every asynchronous input is seen only after SYNC_STAGES clock edges. A change applied just before an edge therefore cannot reach the switch outputs until the edge after the last synchronizer stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dir_i | input | 2 | Per-leg direction: 1 = output high, 0 = output low |
| pwm_i | input | 1 | PWM gate for the low-side switches |
| test_i | input | 1 | Test mode select |
| en_i | input | 2 | Readback of the per-leg enable/diagnostic lines |
| ot_i | input | 2 | High-side overtemperature flags |
| sat_i | input | 2 | Low-side saturation flags |
| open_i | input | 2 | Load-disconnect flags, used in test mode |
| hs_o | output | 2 | High-side switch on commands |
| ls_o | output | 2 | Low-side switch on commands |
| diag_pd_o | output | 2 | Open-drain pull-down enables for the diagnostic lines |
| fault_o | output | 2 | Latched per-leg fault status |

## Verification
The bench targets reversals of direction. A design that switched a leg straight from high-side to low-side would conduct through both switches, or would give a gap shorter than DEAD_CYC. It also raises saturation while the affected low side is off. A design that did not gate this flag with the low-side state would latch a false fault on a leg that is driving high. Faults are dropped and re-raised with the direction held high or low. A latch that cleared on level rather than on a rising edge, or one that tracked the raw flag, would give a `fault_o` that differs from the reference model. In test mode the bench drives direction codes that would select low-side switches in normal mode, so any leak of low-side drive into test mode appears as a mismatch.

// File: rtl/hb_pkg.sv
package hb_pkg;
   typedef enum logic [1:0] {
      LEG_OFF  = 2'd0,
      LEG_HIGH = 2'd1,
      LEG_LOW  = 2'd2
   } leg_state_e;

   localparam int unsigned LEGS = 2;
   // async inputs per leg: dir, en, ot, sat, open; plus shared pwm and test
   localparam int unsigned PER_LEG_INPUTS = 5;
   localparam int unsigned SHARED_INPUTS  = 2;
endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
   parameter int unsigned W      = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   initial assert (STAGES >= 2) else $error("hb_sync: STAGES must be at least 2");
   initial assert (W >= 1) else $error("hb_sync: W must be at least 1");

   logic [W-1:0] pipe [STAGES];

   for (genvar k = 0; k < STAGES; k++) begin : g_stage
      if (k == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) pipe[k] <= '0;
            else        pipe[k] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) pipe[k] <= '0;
            else        pipe[k] <= pipe[k-1];
         end
      end
   end

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/hb_fault_latch.sv
module hb_fault_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic dir_s,
   input  logic test_s,
   input  logic ot_s,
   input  logic sat_s,
   input  logic open_s,
   input  logic ls_on,
   output logic fault_q,
   output logic block_o
);
   logic dir_prev;
   logic dir_rise;
   logic fault_ev;

   assign dir_rise = dir_s & ~dir_prev;
   // saturation is only meaningful while the low side conducts
   assign fault_ev = test_s ? open_s : (ot_s | (sat_s & ls_on));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dir_prev <= 1'b0;
         fault_q  <= 1'b0;
      end else begin
         dir_prev <= dir_s;
         if (fault_ev)      fault_q <= 1'b1;
         else if (dir_rise) fault_q <= 1'b0;
      end
   end

   // a new event blocks the leg in the same cycle it is latched
   assign block_o = fault_q | fault_ev;

   AST_FAULT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
      fault_ev |=> fault_q) else $error("fault event not latched"); // R6
   AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_q && !dir_rise) |=> fault_q) else $error("latch cleared without rising edge"); // R8
endmodule

// File: rtl/hb_leg_fsm.sv
module hb_leg_fsm
   import hb_pkg::*;
#(
   parameter int unsigned DEAD_CYC = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  leg_state_e want,
   output logic       hs_o,
   output logic       ls_o
);
   initial assert (DEAD_CYC >= 1) else $error("hb_leg_fsm: DEAD_CYC must be at least 1");

   localparam int unsigned CW = $clog2(DEAD_CYC + 1);
   localparam logic [CW-1:0] GAP_FULL = CW'(DEAD_CYC);
   localparam logic [CW-1:0] GAP_ONE  = CW'(1);

   leg_state_e    cur;
   logic [CW-1:0] gap;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur <= LEG_OFF;
         gap <= GAP_FULL;
      end else if (cur == LEG_OFF) begin
         if (want != LEG_OFF && gap >= GAP_FULL) cur <= want;
         else if (gap < GAP_FULL)                gap <= gap + GAP_ONE;
      end else if (want != cur) begin
         // turn-off is immediate; turn-on waits for the gap
         cur <= LEG_OFF;
         gap <= GAP_ONE;
      end
   end

   assign hs_o = (cur == LEG_HIGH);
   assign ls_o = (cur == LEG_LOW);

   AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
      !(hs_o && ls_o)) else $error("both switches on"); // R5
   AST_LS_OFF_BEFORE_HS: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ls_o) |-> !hs_o) else $error("high side on as low side fell"); // R5
   AST_HS_OFF_BEFORE_LS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ls_o) |-> !$past(hs_o)) else $error("low side directly after high side"); // R5
endmodule

// File: rtl/hbridge_ctrl.sv
module hbridge_ctrl
   import hb_pkg::*;
#(
   parameter int unsigned DEAD_CYC    = 3,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] dir_i,
   input  logic       pwm_i,
   input  logic       test_i,
   input  logic [1:0] en_i,
   input  logic [1:0] ot_i,
   input  logic [1:0] sat_i,
   input  logic [1:0] open_i,
   output logic [1:0] hs_o,
   output logic [1:0] ls_o,
   output logic [1:0] diag_pd_o,
   output logic [1:0] fault_o
);
   localparam int unsigned SW = LEGS * PER_LEG_INPUTS + SHARED_INPUTS;

   logic [SW-1:0]   raw_in;
   logic [SW-1:0]   syn;
   logic [LEGS-1:0] dir_s, en_s, ot_s, sat_s, open_s;
   logic            pwm_s, test_s;
   logic [LEGS-1:0] fault_q;

   assign raw_in = {pwm_i, test_i, dir_i, en_i, ot_i, sat_i, open_i};

   hb_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_in),
      .q     (syn)
   );

   assign {pwm_s, test_s, dir_s, en_s, ot_s, sat_s, open_s} = syn;

   for (genvar i = 0; i < LEGS; i++) begin : g_leg
      leg_state_e want;
      logic       blk;

      hb_fault_latch u_latch (
         .clk     (clk),
         .rst_n   (rst_n),
         .dir_s   (dir_s[i]),
         .test_s  (test_s),
         .ot_s    (ot_s[i]),
         .sat_s   (sat_s[i]),
         .open_s  (open_s[i]),
         .ls_on   (ls_o[i]),
         .fault_q (fault_q[i]),
         .block_o (blk)
      );

      always_comb begin
         if (blk || !en_s[i])  want = LEG_OFF;
         else if (test_s)      want = dir_s[i] ? LEG_HIGH : LEG_OFF;
         else if (dir_s[i])    want = LEG_HIGH;
         else if (pwm_s)       want = LEG_LOW;
         else                  want = LEG_OFF;
      end

      hb_leg_fsm #(.DEAD_CYC(DEAD_CYC)) u_fsm (
         .clk   (clk),
         .rst_n (rst_n),
         .want  (want),
         .hs_o  (hs_o[i]),
         .ls_o  (ls_o[i])
      );

      AST_ENABLE_LOW_OFF: assert property (@(posedge clk) disable iff (!rst_n)
         !en_s[i] |=> (!hs_o[i] && !ls_o[i])) else $error("disabled leg conducts"); // R4
      AST_FAULT_LEG_OFF: assert property (@(posedge clk) disable iff (!rst_n)
         fault_q[i] |-> (!hs_o[i] && !ls_o[i])) else $error("faulted leg conducts"); // R6
   end

   assign diag_pd_o = fault_q;
   assign fault_o   = fault_q;

   AST_PWM_LOW_NO_LS: assert property (@(posedge clk) disable iff (!rst_n)
      !pwm_s |=> (ls_o == '0)) else $error("low side on with pwm low"); // R3
   AST_TEST_NO_LS: assert property (@(posedge clk) disable iff (!rst_n)
      test_s |=> (ls_o == '0)) else $error("low side on in test mode"); // R10
endmodule

// File: tb/tb_hbridge_ctrl.sv
`timescale 1ns/1ps
module tb_hbridge_ctrl;
   localparam int D = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] dir = 2'b00, en = 2'b11, ot = 2'b00, sat = 2'b00, opn = 2'b00;
   logic       pwm = 1'b0, tm = 1'b0;
   logic [1:0] hs, ls, pd, flt;

   int checks = 0;
   int fails  = 0;
   string phase = "R1";

   always #10 clk = ~clk;

   hbridge_ctrl #(.DEAD_CYC(D), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .dir_i(dir), .pwm_i(pwm), .test_i(tm),
      .en_i(en), .ot_i(ot), .sat_i(sat), .open_i(opn),
      .hs_o(hs), .ls_o(ls), .diag_pd_o(pd), .fault_o(flt)
   );

   // behavioural reference: state 0 off, 1 high side, 2 low side
   int   m_st[2];
   int   m_gap[2];
   bit   m_flt[2];
   bit   m_dp[2];
   logic [11:0] q1, q2;
   int   offrun[2];
   int   prev_on[2];

   function automatic void chk(input bit ok, input string req, input string what,
                               input logic [1:0] act, input logic [1:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
      end
   endfunction

   always @(posedge clk) begin
      logic [1:0] eh, el, ef;
      if (!rst_n) begin
         for (int i = 0; i < 2; i++) begin
            m_st[i] = 0; m_gap[i] = D; m_flt[i] = 0; m_dp[i] = 0;
         end
         q1 = '0; q2 = '0;
      end else begin
         for (int i = 0; i < 2; i++) begin
            bit dr, e, o, s, op, ev, rise, blk;
            int want;
            dr = q2[i]; e = q2[2+i]; o = q2[4+i]; s = q2[6+i]; op = q2[8+i];
            ev   = q2[11] ? op : (o | (s & (m_st[i] == 2)));
            rise = dr & !m_dp[i];
            blk  = m_flt[i] | ev;
            if (blk || !e)     want = 0;
            else if (q2[11])   want = dr ? 1 : 0;
            else if (dr)       want = 1;
            else if (q2[10])   want = 2;
            else               want = 0;
            if (ev) m_flt[i] = 1; else if (rise) m_flt[i] = 0;
            m_dp[i] = dr;
            if (m_st[i] == 0) begin
               if (want != 0 && m_gap[i] >= D) m_st[i] = want;
               else if (m_gap[i] < D) m_gap[i]++;
            end else if (want != m_st[i]) begin
               m_st[i] = 0; m_gap[i] = 1;
            end
         end
         q2 = q1;
         q1 = {tm, pwm, opn, sat, ot, en, dir};
      end
      #5;
      for (int i = 0; i < 2; i++) begin
         eh[i] = (m_st[i] == 1); el[i] = (m_st[i] == 2); ef[i] = m_flt[i];
      end
      chk(hs == eh, phase, "hs_o vs model", hs, eh);
      chk(ls == el, phase, "ls_o vs model", ls, el);
      chk(pd == ef, phase, "diag_pd_o vs model", pd, ef);
      chk(flt == ef, phase, "fault_o vs model", flt, ef);
      // R5: independent gap monitor per leg
      for (int i = 0; i < 2; i++) begin
         int now_on;
         now_on = hs[i] ? 1 : (ls[i] ? 2 : 0);
         if (!rst_n) begin
            offrun[i] = D;
         end else begin
            chk(!(hs[i] && ls[i]), "R5", "both switches on", {hs[i], ls[i]}, 2'b00);
            if (now_on != 0 && prev_on[i] == 0)
               chk(offrun[i] >= D, "R5", "gap too short", 2'(offrun[i]), 2'(D));
            if (now_on != 0 && prev_on[i] != 0)
               chk(now_on == prev_on[i], "R5", "direct switch swap", 2'(now_on), 2'(prev_on[i]));
            offrun[i] = (now_on == 0) ? offrun[i] + 1 : 0;
         end
         prev_on[i] = now_on;
      end
   end

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect4(input string req, input logic [1:0] eh, input logic [1:0] el,
                          input logic [1:0] ef);
      chk(hs == eh, req, "hs_o", hs, eh);
      chk(ls == el, req, "ls_o", ls, el);
      chk(flt == ef, req, "fault_o", flt, ef);
      chk(pd == ef, req, "diag_pd_o", pd, ef);
   endtask

   initial begin
      prev_on[0] = 0; prev_on[1] = 0; offrun[0] = D; offrun[1] = D;
      // R1: reset state
      settle(5);
      expect4("R1", 2'b00, 2'b00, 2'b00);
      rst_n = 1'b1;

      // R2: direction codes
      phase = "R2"; pwm = 1'b1;
      dir = 2'b01; settle(12); expect4("R2", 2'b01, 2'b10, 2'b00);
      dir = 2'b10; settle(12); expect4("R2", 2'b10, 2'b01, 2'b00);
      dir = 2'b11; settle(12); expect4("R2", 2'b11, 2'b00, 2'b00);
      dir = 2'b00; settle(12); expect4("R2", 2'b00, 2'b11, 2'b00);

      // R11: two-stage delay before anything moves
      phase = "R11"; dir = 2'b11;
      settle(1); expect4("R11", 2'b00, 2'b11, 2'b00);
      settle(12); expect4("R11", 2'b11, 2'b00, 2'b00);

      // R3: pwm gates only the low sides
      phase = "R3"; dir = 2'b01; pwm = 1'b0;
      settle(12); expect4("R3", 2'b01, 2'b00, 2'b00);
      pwm = 1'b1; settle(12); expect4("R3", 2'b01, 2'b10, 2'b00);

      // R4: enable line low disables one leg only
      phase = "R4"; en = 2'b10;
      settle(12); expect4("R4", 2'b00, 2'b10, 2'b00);
      en = 2'b11; settle(12); expect4("R4", 2'b01, 2'b10, 2'b00);

      // R6 / R9: overtemperature on leg A, flag then dropped
      phase = "R6"; ot = 2'b01; settle(2); ot = 2'b00;
      settle(12); expect4("R6", 2'b00, 2'b10, 2'b01);
      phase = "R9"; settle(10); expect4("R9", 2'b00, 2'b10, 2'b01);

      // R8: only a rising direction edge clears
      phase = "R8"; dir = 2'b00; settle(12); expect4("R8", 2'b00, 2'b10, 2'b01);
      dir = 2'b01; settle(12); expect4("R8", 2'b01, 2'b10, 2'b00);

      // R7: saturation counts on a conducting low side only
      phase = "R7"; sat = 2'b10; settle(2); sat = 2'b00;
      settle(12); expect4("R7", 2'b01, 2'b00, 2'b10);
      dir = 2'b11; settle(12); dir = 2'b01; settle(12);
      expect4("R7", 2'b01, 2'b10, 2'b00);
      sat = 2'b01; settle(6); sat = 2'b00;
      settle(6); expect4("R7", 2'b01, 2'b10, 2'b00);

      // R10: test mode drives high sides only, open flag latches
      phase = "R10"; tm = 1'b1; dir = 2'b11;
      settle(12); expect4("R10", 2'b11, 2'b00, 2'b00);
      dir = 2'b01; opn = 2'b10; settle(2); opn = 2'b00;
      settle(12); expect4("R10", 2'b01, 2'b00, 2'b10);
      tm = 1'b0; dir = 2'b11; settle(12);
      expect4("R10", 2'b11, 2'b00, 2'b00);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #(200000 * 20);
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule